// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a small 32-bit processor that completes every instruction in one clock. It implements seven instructions: load word, store word, branch-if-equal, and the register-to-register operations add, subtract, AND and OR. The block holds the program counter, a 32-entry by 32-bit register file, an immediate extractor, an arithmetic unit with a zero flag, and a two-level decoder. The first level turns the opcode into a 2-bit operation class. The second level combines that class with instruction bit 30 and bits 14:12 to form a 4-bit arithmetic command.

Program and data storage are small word-indexed arrays inside the block. While reset is held, they are filled through dedicated load ports. Two combinational peek ports let a register and a data word be read out so that results can be observed. The program counter is exposed as an output. It is written on every clock edge, with either the fall-through address or the branch target.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset drives `pc` to 0 and clears all registers. The load ports write the program and data arrays only while reset is high, and stores from the core are blocked during reset.
- R2: When reset is low and no branch is taken, `pc` becomes the old `pc` plus 4 on every rising edge.
- R3: Branch-if-equal (opcode 1100011) compares the registers selected by bits 19:15 and 24:20. When they are equal, `pc` becomes `pc` plus the sign-extended offset {bit31, bit7, bits30:25, bits11:8, 0}. When they differ, `pc` becomes `pc` plus 4.
- R4: The arithmetic command is 0010 add, 0110 subtract, 0000 AND and 0001 OR. Operation class 00 (loads and stores) forces add and class 01 (branch) forces subtract. Class 10 decodes bit 30 and bits 14:12: 0/000 gives add, 1/000 gives subtract, 111 gives AND and 110 gives OR.
- R5: An instruction with opcode 0110011 writes the result of the operation on rs1 (bits 19:15) and rs2 (bits 24:20) into rd (bits 11:7). It does not touch data memory.
- R6: Load word (opcode 0000011) writes the data word at rs1 plus the sign-extended bits 31:20 into rd. Negative offsets are included.
- R7: Store word (opcode 0100011) writes rs2 to the data word at rs1 plus the sign-extended {bits31:25, bits11:7}. It writes no register.
- R8: Branch-if-equal writes neither a register nor data memory, whether or not it is taken.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: Both arrays are indexed by byte-address bits [AW+1:2]. `peek_reg_data` and `peek_mem_data` show the selected entry combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| prog_wr_en | input | 1 | Program array load strobe (honoured only in reset) |
| prog_wr_idx | input | IMEM_AW | Program word index |
| prog_wr_data | input | 32 | Program word to load |
| data_wr_en | input | 1 | Data array load strobe (honoured only in reset) |
| data_wr_idx | input | DMEM_AW | Data word index |
| data_wr_data | input | 32 | Data word to load |
| peek_reg_idx | input | 5 | Register to observe |
| peek_reg_data | output | 32 | Value of the observed register |
| peek_mem_idx | input | DMEM_AW | Data word to observe |
| peek_mem_data | output | 32 | Value of the observed data word |
| pc | output | 32 | Current program counter |

## Verification
On every cycle, the assertions check the following:
- the program counter sequencing, both the fall-through step and the taken-branch target;
- the fixed arithmetic commands for the load/store class and the branch class;
- that the branch never writes state, and that only stores write memory;
- that register 0 reads back as zero.

Other behaviours can only be shown by the bench's programs, because they depend on data flowing through several instructions:
- the funct-field decode, seen through the actual add, subtract, AND and OR results;
- load and store addressing, including negative offsets;
- the final register and memory contents, compared against an instruction-level model over directed and random programs.

// File: rtl/sc_core.sv
module sc_core #(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               prog_wr_en,
  input  logic [IMEM_AW-1:0] prog_wr_idx,
  input  logic [31:0]        prog_wr_data,
  input  logic               data_wr_en,
  input  logic [DMEM_AW-1:0] data_wr_idx,
  input  logic [31:0]        data_wr_data,
  input  logic [4:0]         peek_reg_idx,
  output logic [31:0]        peek_reg_data,
  input  logic [DMEM_AW-1:0] peek_mem_idx,
  output logic [31:0]        peek_mem_data,
  output logic [31:0]        pc
);
  localparam int IMEM_WORDS = 1 << IMEM_AW;
  localparam int DMEM_WORDS = 1 << DMEM_AW;
  localparam logic [6:0] OPC_ALU    = 7'b0110011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;

  logic [31:0] prog_mem [IMEM_WORDS];
  logic [31:0] data_mem [DMEM_WORDS];
  logic [31:0] regs     [32];

  logic [31:0] instr;
  logic [6:0]  opcode;
  logic [4:0]  rs1_idx, rs2_idx, rd_idx;
  logic [2:0]  funct3;
  logic        alu_src, mem_to_reg, reg_write, mem_read, mem_write, branch;
  logic [1:0]  alu_op;
  logic [3:0]  alu_ctl;
  logic [31:0] imm, rs1_val, rs2_val, opnd_b, alu_res, load_val, wb_val;
  logic        zero, take_branch;

  assign instr   = prog_mem[pc[IMEM_AW+1:2]];
  assign opcode  = instr[6:0];
  assign rd_idx  = instr[11:7];
  assign funct3  = instr[14:12];
  assign rs1_idx = instr[19:15];
  assign rs2_idx = instr[24:20];

  always_comb begin
    alu_src = 1'b0; mem_to_reg = 1'b0; reg_write = 1'b0;
    mem_read = 1'b0; mem_write = 1'b0; branch = 1'b0; alu_op = 2'b00;
    case (opcode)
      OPC_ALU:    begin reg_write = 1'b1; alu_op = 2'b10; end
      OPC_LOAD:   begin alu_src = 1'b1; mem_to_reg = 1'b1; reg_write = 1'b1; mem_read = 1'b1; end
      OPC_STORE:  begin alu_src = 1'b1; mem_write = 1'b1; end
      OPC_BRANCH: begin branch = 1'b1; alu_op = 2'b01; end
      default: ;
    endcase
  end

  always_comb begin
    if (instr[6])
      imm = {{19{instr[31]}}, instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
    else if (instr[5])
      imm = {{20{instr[31]}}, instr[31:25], instr[11:7]};
    else
      imm = {{20{instr[31]}}, instr[31:20]};
  end

  always_comb begin
    casez (alu_op)
      2'b00: alu_ctl = 4'b0010;
      2'b?1: alu_ctl = 4'b0110;
      default:
        casez ({instr[30], funct3})
          4'b0000: alu_ctl = 4'b0010;
          4'b1000: alu_ctl = 4'b0110;
          4'b?111: alu_ctl = 4'b0000;
          4'b?110: alu_ctl = 4'b0001;
          default: alu_ctl = 4'b0010;
        endcase
    endcase
  end

  assign rs1_val = (rs1_idx == 5'd0) ? 32'd0 : regs[rs1_idx];
  assign rs2_val = (rs2_idx == 5'd0) ? 32'd0 : regs[rs2_idx];
  assign opnd_b  = alu_src ? imm : rs2_val;

  always_comb begin
    case (alu_ctl)
      4'b0000: alu_res = rs1_val & opnd_b;
      4'b0001: alu_res = rs1_val | opnd_b;
      4'b0010: alu_res = rs1_val + opnd_b;
      4'b0110: alu_res = rs1_val - opnd_b;
      default: alu_res = 32'd0;
    endcase
  end

  assign zero        = (alu_res == 32'd0);
  assign take_branch = branch & zero;
  assign load_val    = mem_read ? data_mem[alu_res[DMEM_AW+1:2]] : 32'd0;
  assign wb_val      = mem_to_reg ? load_val : alu_res;

  always_ff @(posedge clk) begin
    if (rst) pc <= 32'd0;
    else     pc <= take_branch ? pc + imm : pc + 32'd4;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 32; k++) regs[k] <= 32'd0;
    end else if (reg_write && rd_idx != 5'd0) begin
      regs[rd_idx] <= wb_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst && prog_wr_en) prog_mem[prog_wr_idx] <= prog_wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      if (data_wr_en) data_mem[data_wr_idx] <= data_wr_data;
    end else if (mem_write) begin
      data_mem[alu_res[DMEM_AW+1:2]] <= rs2_val;
    end
  end

  assign peek_reg_data = (peek_reg_idx == 5'd0) ? 32'd0 : regs[peek_reg_idx];
  assign peek_mem_data = data_mem[peek_mem_idx];
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic        branch,
  input logic        zero,
  input logic [31:0] imm,
  input logic [1:0]  alu_op,
  input logic [3:0]  alu_ctl,
  input logic [6:0]  opcode,
  input logic        reg_write,
  input logic        mem_write,
  input logic [4:0]  peek_reg_idx,
  input logic [31:0] peek_reg_data
);
  // R1
  reset_pc_chk: assert property (@(posedge clk) rst |=> pc == 32'd0);
  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !(branch && zero) |=> pc == $past(pc) + 32'd4);
  // R3
  pc_branch_chk: assert property (@(posedge clk) disable iff (rst)
    (branch && zero) |=> pc == $past(pc) + $past(imm));
  // R4
  cls_add_chk: assert property (@(posedge clk) disable iff (rst)
    alu_op == 2'b00 |-> alu_ctl == 4'b0010);
  // R4
  cls_sub_chk: assert property (@(posedge clk) disable iff (rst)
    alu_op == 2'b01 |-> alu_ctl == 4'b0110);
  // R8
  branch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    opcode == 7'b1100011 |-> !reg_write && !mem_write);
  // R7
  store_only_chk: assert property (@(posedge clk) disable iff (rst)
    mem_write |-> opcode == 7'b0100011 && !reg_write);
  // R9
  x0_zero_chk: assert property (@(posedge clk) disable iff (rst)
    peek_reg_idx == 5'd0 |-> peek_reg_data == 32'd0);
endmodule

bind sc_core sc_core_chk u_chk (
  .clk(clk), .rst(rst), .pc(pc), .branch(branch), .zero(zero), .imm(imm),
  .alu_op(alu_op), .alu_ctl(alu_ctl), .opcode(opcode), .reg_write(reg_write),
  .mem_write(mem_write), .peek_reg_idx(peek_reg_idx), .peek_reg_data(peek_reg_data)
);

// File: tb/sc_core_bench.sv
module sc_core_bench;
  localparam int AW = 6;
  localparam int WORDS = 1 << AW;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic prog_wr_en = 1'b0, data_wr_en = 1'b0;
  logic [AW-1:0] prog_wr_idx = '0, data_wr_idx = '0, peek_mem_idx = '0;
  logic [31:0] prog_wr_data = '0, data_wr_data = '0;
  logic [4:0] peek_reg_idx = '0;
  logic [31:0] peek_reg_data, peek_mem_data, pc;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [31:0] prog [WORDS];
  logic [31:0] dinit [WORDS];
  logic [31:0] mr [32];
  logic [31:0] mm [WORDS];
  logic [31:0] mpc;
  bit m_taken;

  always #(PERIOD/2) clk = ~clk;

  sc_core #(.IMEM_AW(AW), .DMEM_AW(AW)) u_sc_core (
    .clk(clk), .rst(rst),
    .prog_wr_en(prog_wr_en), .prog_wr_idx(prog_wr_idx), .prog_wr_data(prog_wr_data),
    .data_wr_en(data_wr_en), .data_wr_idx(data_wr_idx), .data_wr_data(data_wr_data),
    .peek_reg_idx(peek_reg_idx), .peek_reg_data(peek_reg_data),
    .peek_mem_idx(peek_mem_idx), .peek_mem_data(peek_mem_data), .pc(pc));

  function automatic logic [31:0] enc_r(logic sub, logic [2:0] f3, logic [4:0] rd, logic [4:0] rs1, logic [4:0] rs2);
    return {1'b0, sub, 5'b0, rs2, rs1, f3, rd, 7'b0110011};
  endfunction
  function automatic logic [31:0] enc_lw(logic [4:0] rd, logic [4:0] rs1, logic [31:0] off);
    return {off[11:0], rs1, 3'b010, rd, 7'b0000011};
  endfunction
  function automatic logic [31:0] enc_sw(logic [4:0] rs2, logic [4:0] rs1, logic [31:0] off);
    return {off[11:5], rs2, rs1, 3'b010, off[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] enc_beq(logic [4:0] rs1, logic [4:0] rs2, logic [31:0] off);
    return {off[12], off[10:5], rs2, rs1, 3'b000, off[4:1], off[11], 7'b1100011};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic [31:0] i, a, b, res, addr;
    i = prog[mpc[AW+1:2]];
    a = mr[i[19:15]];
    b = mr[i[24:20]];
    m_taken = 1'b0;
    case (i[6:0])
      7'b0110011: begin
        case (i[14:12])
          3'b111: res = a & b;
          3'b110: res = a | b;
          default: res = i[30] ? a - b : a + b;
        endcase
        if (i[11:7] != 0) mr[i[11:7]] = res;
        mpc = mpc + 4;
      end
      7'b0000011: begin
        addr = a + {{20{i[31]}}, i[31:20]};
        if (i[11:7] != 0) mr[i[11:7]] = mm[addr[AW+1:2]];
        mpc = mpc + 4;
      end
      7'b0100011: begin
        addr = a + {{20{i[31]}}, i[31:25], i[11:7]};
        mm[addr[AW+1:2]] = b;
        mpc = mpc + 4;
      end
      7'b1100011: begin
        m_taken = (a == b);
        mpc = m_taken ? mpc + {{19{i[31]}}, i[31], i[7], i[30:25], i[11:8], 1'b0} : mpc + 4;
      end
      default: mpc = mpc + 4;
    endcase
  endtask

  task automatic load_and_reset();
    @(negedge clk);
    rst = 1'b1;
    for (int k = 0; k < WORDS; k++) begin
      prog_wr_en = 1'b1; prog_wr_idx = k[AW-1:0]; prog_wr_data = prog[k];
      data_wr_en = 1'b1; data_wr_idx = k[AW-1:0]; data_wr_data = dinit[k];
      @(negedge clk);
    end
    prog_wr_en = 1'b0; data_wr_en = 1'b0;
    @(negedge clk);
    for (int k = 0; k < 32; k++) mr[k] = 32'd0;
    for (int k = 0; k < WORDS; k++) mm[k] = dinit[k];
    mpc = 32'd0;
    chk("R1 pc in reset", pc, 32'd0);
    peek_reg_idx = 5'd3; #1;
    chk("R1 register cleared", peek_reg_data, 32'd0);
  endtask

  task automatic run(input int cycles);
    rst = 1'b0;
    for (int c = 0; c < cycles; c++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk(m_taken ? "R3 branch target" : "R2 sequential pc", pc, mpc);
    end
  endtask

  task automatic compare_state();
    for (int k = 0; k < 32; k++) begin
      peek_reg_idx = k[4:0]; #1;
      chk(k == 0 ? "R9 x0 register" : "R5 register file", peek_reg_data, mr[k]);
    end
    for (int k = 0; k < WORDS; k++) begin
      peek_mem_idx = k[AW-1:0]; #1;
      chk("R7 data memory", peek_mem_data, mm[k]);
    end
  endtask

  task automatic finish_test();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_test();
  end

  initial begin
    logic [31:0] w1, w2;
    void'($urandom(32'd1234));
    // directed program
    for (int k = 0; k < WORDS; k++) begin
      prog[k] = enc_beq(5'd0, 5'd0, 32'd0);
      dinit[k] = $urandom;
    end
    w1 = 32'hF0F0_1234; w2 = 32'h0FF0_8765;
    dinit[0] = 32'h40; dinit[1] = w1; dinit[2] = w2;
    prog[0]  = enc_lw(5'd1, 5'd0, 32'd0);
    prog[1]  = enc_lw(5'd2, 5'd0, 32'd4);
    prog[2]  = enc_lw(5'd3, 5'd0, 32'd8);
    prog[3]  = enc_r(1'b0, 3'b000, 5'd4, 5'd2, 5'd3);
    prog[4]  = enc_r(1'b1, 3'b000, 5'd5, 5'd2, 5'd3);
    prog[5]  = enc_r(1'b0, 3'b111, 5'd6, 5'd2, 5'd3);
    prog[6]  = enc_r(1'b0, 3'b110, 5'd7, 5'd2, 5'd3);
    prog[7]  = enc_lw(5'd8, 5'd1, -32'sd60);
    prog[8]  = enc_sw(5'd7, 5'd1, 32'd12);
    prog[9]  = enc_r(1'b0, 3'b000, 5'd0, 5'd2, 5'd3);
    prog[10] = enc_beq(5'd2, 5'd3, 32'd8);
    prog[11] = enc_r(1'b0, 3'b000, 5'd9, 5'd2, 5'd2);
    prog[12] = enc_beq(5'd4, 5'd4, 32'd8);
    prog[13] = enc_r(1'b0, 3'b000, 5'd10, 5'd2, 5'd2);
    prog[14] = enc_sw(5'd5, 5'd0, 32'd0);
    load_and_reset();
    run(20);
    peek_reg_idx = 5'd4; #1; chk("R4 R5 add result", peek_reg_data, w1 + w2);
    peek_reg_idx = 5'd5; #1; chk("R4 R5 subtract result", peek_reg_data, w1 - w2);
    peek_reg_idx = 5'd6; #1; chk("R4 R5 AND result", peek_reg_data, w1 & w2);
    peek_reg_idx = 5'd7; #1; chk("R4 R5 OR result", peek_reg_data, w1 | w2);
    peek_reg_idx = 5'd8; #1; chk("R6 load negative offset", peek_reg_data, w1);
    peek_reg_idx = 5'd0; #1; chk("R9 write to x0 dropped", peek_reg_data, 32'd0);
    peek_reg_idx = 5'd9; #1; chk("R8 not-taken branch falls through", peek_reg_data, w1 + w1);
    peek_reg_idx = 5'd10; #1; chk("R3 taken branch skips", peek_reg_data, 32'd0);
    peek_mem_idx = 6'd19; #1; chk("R7 R10 store via base+offset", peek_mem_data, w1 | w2);
    peek_mem_idx = 6'd0; #1; chk("R7 store at word 0", peek_mem_data, w1 - w2);
    compare_state();

    // random programs checked against the model
    for (int p = 0; p < 4; p++) begin
      int len;
      len = 40;
      for (int k = 0; k < WORDS; k++) begin
        prog[k] = enc_beq(5'd0, 5'd0, 32'd0);
        dinit[k] = $urandom;
      end
      for (int k = 0; k < 6; k++)
        prog[k] = enc_lw(5'(k + 1), 5'd0, 32'(4 * ($urandom % WORDS)));
      for (int k = 6; k < len; k++) begin
        int sel;
        sel = $urandom % 10;
        if (sel < 5) begin
          case ($urandom % 4)
            0: prog[k] = enc_r(1'b0, 3'b000, 5'($urandom % 16), 5'($urandom % 16), 5'($urandom % 16));
            1: prog[k] = enc_r(1'b1, 3'b000, 5'($urandom % 16), 5'($urandom % 16), 5'($urandom % 16));
            2: prog[k] = enc_r(1'b0, 3'b111, 5'($urandom % 16), 5'($urandom % 16), 5'($urandom % 16));
            default: prog[k] = enc_r(1'b0, 3'b110, 5'($urandom % 16), 5'($urandom % 16), 5'($urandom % 16));
          endcase
        end else if (sel < 7) begin
          prog[k] = enc_lw(5'($urandom % 16), 5'd0, 32'(4 * ($urandom % WORDS)));
        end else if (sel < 8) begin
          prog[k] = enc_sw(5'($urandom % 16), 5'd0, 32'(4 * ($urandom % WORDS)));
        end else begin
          logic [4:0] ra, rb;
          int skip;
          ra = 5'($urandom % 8);
          rb = ($urandom % 2 == 0) ? ra : 5'($urandom % 8);
          skip = 1 + $urandom % 3;
          if (k + skip > len) skip = len - k;
          prog[k] = enc_beq(ra, rb, 32'(4 * skip));
        end
      end
      load_and_reset();
      run(len + 6);
      compare_state();
    end
    finish_test();
  end
endmodule